// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Slave Port

This block is a synchronous slave port through which a host processor reads and writes a 1024-entry, 64-bit internal storage array. The bus is pipelined and uses late writes. Address, direction, byte-write enables and the three chip selects are captured on a rising clock edge. For a write, the data arrives one cycle later. For a read, the data is driven back one cycle later.

Any cycle may carry a read, a write or nothing, in any order, with no idle cycles between them. A read that lands on the address of a write whose data is still in flight returns that data, merged lane by lane with the stored contents. The bidirectional data bus is modelled as separate input and output buses plus an output enable. The output enable is raised only in the cycle that carries read data, so the host owns the bus in every other cycle.

Top module: `lw_sram_port`

## Requirements
- R1: A synchronous active-high reset clears the pending-write stage, the output enable and the output data register. A write whose data cycle coincides with reset is discarded. Memory contents are not initialised.
- R2: A cycle is selected only when `sel0_n_i` is 0, `sel1_i` is 1 and `sel2_n_i` is 0. Any other combination is a no-operation that writes nothing and raises no output enable.
- R3: A selected cycle with `rd_wr_n_i` = 0 is a write. Its data is taken from `dq_i` at the next rising edge and stored at the address captured one edge earlier.
- R4: A selected cycle with `rd_wr_n_i` = 1 is a read. The stored word is driven on `dq_o` with `dq_oe_o` = 1 during the following cycle. `dq_oe_o` is 0 in every cycle that does not follow a selected read.
- R5: Byte-write enable bit k (active low) guards data bits [8k+7:8k]. Only lanes whose bit is 0 are updated, and the other lanes keep their stored value.
- R6: A read issued in the cycle directly after a write to the same address returns the write's data in the enabled lanes and the previously stored data in the others.
- R7: Reads and writes can be interleaved in every cycle, in either order, with no idle cycle, and each returns or stores correct data.
- R8: The global write-enable input `gwe_n_i` has no effect on any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| adr_i | input | 10 | Word address |
| rd_wr_n_i | input | 1 | 1 = read, 0 = write |
| bw_n_i | input | 8 | Active-low byte-write enables, one per 8-bit lane |
| sel0_n_i | input | 1 | Active-low chip select |
| sel1_i | input | 1 | Active-high chip select |
| sel2_n_i | input | 1 | Active-low chip select |
| gwe_n_i | input | 1 | Global write enable, ignored |
| dq_i | input | 64 | Write data from the host, one cycle after the address |
| dq_o | output | 64 | Read data to the host |
| dq_oe_o | output | 1 | Output enable for `dq_o` |

## Verification
The hardest case to reach from the ports is a read that arrives while an earlier write's data is still on the input bus and not yet in the array. This is especially hard with a partial byte mask, because the returned word must then be assembled from two sources. The stimulus first writes a known full word to an address. It then issues a masked write to that address, followed at once by a read of it, so the read's capture edge is the same edge that samples the write data. Deselected writes, the ignored write-enable pin and a reset that lands on a write's data cycle are each followed by a read-back of the affected address.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Decoded bus operation for one cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } lw_op_e;

endpackage

// File: rtl/lw_cmd_decode.sv
module lw_cmd_decode
    import lw_sram_pkg::*;
(
    input  logic   rd_wr_n_i,
    input  logic   sel0_n_i,
    input  logic   sel1_i,
    input  logic   sel2_n_i,
    output lw_op_e op_o
);

    logic selected;

    always_comb begin
        selected = !sel0_n_i && sel1_i && !sel2_n_i;
        if (!selected) begin
            op_o = OP_IDLE;
        end else if (rd_wr_n_i) begin
            op_o = OP_READ;
        end else begin
            op_o = OP_WRITE;
        end
    end

endmodule

// File: rtl/lw_wr_pipe.sv
module lw_wr_pipe
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  lw_op_e            op_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [LANES-1:0]  bw_n_i,
    output logic              pend_valid_o,
    output logic [ADDR_W-1:0] pend_adr_o,
    output logic [LANES-1:0]  pend_lane_o
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] adr;
        logic [LANES-1:0]  lane;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        pend_d.valid = (op_i == OP_WRITE);
        if (op_i == OP_WRITE) begin
            pend_d.adr  = adr_i;
            pend_d.lane = ~bw_n_i;
        end else begin
            pend_d.lane = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_valid_o = pend_q.valid;
    assign pend_adr_o   = pend_q.adr;
    assign pend_lane_o  = pend_q.lane;

    // R3
    wr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_WRITE) |=> pend_valid_o);

    // R2
    no_stray_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_WRITE) |=> (!pend_valid_o && pend_lane_o == '0));

    // R5
    lane_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_WRITE) |=> (pend_lane_o == ~$past(bw_n_i)));

endmodule

// File: rtl/lw_mem_array.sv
module lw_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_adr_i,
    input  logic [DATA_W/LANE_W-1:0] wr_lane_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_adr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en_i && wr_lane_i[l]) begin
                lane_mem_q[wr_adr_i] <= wr_data_i[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data_o[l*LANE_W +: LANE_W] = lane_mem_q[rd_adr_i];
    end

endmodule

// File: rtl/lw_rd_stage.sv
module lw_rd_stage
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  lw_op_e            op_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              pend_valid_i,
    input  logic [ADDR_W-1:0] pend_adr_i,
    input  logic [DATA_W/LANE_W-1:0] pend_lane_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              oe_o
);

    localparam int LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    logic              hit;
    logic [DATA_W-1:0] merged;

    assign hit = pend_valid_i && (pend_adr_i == adr_i);

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] = (hit && pend_lane_i[l])
            ? bus_wdata_i[l*LANE_W +: LANE_W]
            : mem_rdata_i[l*LANE_W +: LANE_W];
    end

    always_comb begin
        rd_d    = rd_q;
        rd_d.oe = (op_i == OP_READ);
        if (op_i == OP_READ) begin
            rd_d.data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.data;
    assign oe_o    = rd_q.oe;

    // R4
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_READ) |=> oe_o);

    // R4
    oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_READ) |=> !oe_o);

    // R6
    fwd_full_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_READ && pend_valid_i && pend_adr_i == adr_i && (&pend_lane_i))
        |=> (rdata_o == $past(bus_wdata_i)));

    // R6
    no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_READ && !pend_valid_i) |=> (rdata_o == $past(mem_rdata_i)));

endmodule

// File: rtl/lw_sram_port.sv
module lw_sram_port
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          adr_i,
    input  logic                       rd_wr_n_i,
    input  logic [DATA_W/LANE_W-1:0]   bw_n_i,
    input  logic                       sel0_n_i,
    input  logic                       sel1_i,
    input  logic                       sel2_n_i,
    input  logic                       gwe_n_i,
    input  logic [DATA_W-1:0]          dq_i,
    output logic [DATA_W-1:0]          dq_o,
    output logic                       dq_oe_o
);

    localparam int LANES = DATA_W / LANE_W;

    lw_op_e            op;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_adr;
    logic [LANES-1:0]  pend_lane;
    logic              commit_en;
    logic [DATA_W-1:0] mem_rdata;

    // The global write enable plays no part in late-write operation
    logic unused_gwe;
    assign unused_gwe = gwe_n_i;

    // A write whose data edge coincides with reset is dropped
    assign commit_en = pend_valid && !rst;

    lw_cmd_decode u_decode (
        .rd_wr_n_i (rd_wr_n_i),
        .sel0_n_i  (sel0_n_i),
        .sel1_i    (sel1_i),
        .sel2_n_i  (sel2_n_i),
        .op_o      (op)
    );

    lw_wr_pipe #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_wr_pipe (
        .clk          (clk),
        .rst          (rst),
        .op_i         (op),
        .adr_i        (adr_i),
        .bw_n_i       (bw_n_i),
        .pend_valid_o (pend_valid),
        .pend_adr_o   (pend_adr),
        .pend_lane_o  (pend_lane)
    );

    lw_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_mem (
        .clk       (clk),
        .wr_en_i   (commit_en),
        .wr_adr_i  (pend_adr),
        .wr_lane_i (pend_lane),
        .wr_data_i (dq_i),
        .rd_adr_i  (adr_i),
        .rd_data_o (mem_rdata)
    );

    lw_rd_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_rd (
        .clk          (clk),
        .rst          (rst),
        .op_i         (op),
        .adr_i        (adr_i),
        .mem_rdata_i  (mem_rdata),
        .pend_valid_i (pend_valid),
        .pend_adr_i   (pend_adr),
        .pend_lane_i  (pend_lane),
        .bus_wdata_i  (dq_i),
        .rdata_o      (dq_o),
        .oe_o         (dq_oe_o)
    );

    // R2
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(!sel0_n_i && sel1_i && !sel2_n_i) |=> (!dq_oe_o && !pend_valid));

endmodule

// File: tb/lw_sram_port_tb_top.sv
module lw_sram_port_tb_top;

    localparam int K_NOP = 0;
    localparam int K_RD  = 1;
    localparam int K_WR  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  adr = '0;
    logic        rd_wr_n = 1'b1;
    logic [7:0]  bw_n = 8'hFF;
    logic        sel0_n = 1'b1;
    logic        sel1 = 1'b0;
    logic        sel2_n = 1'b1;
    logic        gwe_n = 1'b1;
    logic [63:0] dq_i = '0;
    logic [63:0] dq_o;
    logic        dq_oe;

    int n_total = 0;
    int n_fail  = 0;

    logic [63:0] model [1024];
    int          prev_kind = K_NOP;
    int          prev_adr  = 0;
    logic [7:0]  prev_bw   = 8'hFF;
    logic [63:0] prev_wdata = '0;
    logic [63:0] prev_exp  = '0;
    string       prev_tag  = "R4";

    always #2 clk = ~clk;

    lw_sram_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .adr_i     (adr),
        .rd_wr_n_i (rd_wr_n),
        .bw_n_i    (bw_n),
        .sel0_n_i  (sel0_n),
        .sel1_i    (sel1),
        .sel2_n_i  (sel2_n),
        .gwe_n_i   (gwe_n),
        .dq_i      (dq_i),
        .dq_o      (dq_o),
        .dq_oe_o   (dq_oe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: checks the previous cycle's result, then drives this one
    task automatic step(input int kind, input int a, input logic [7:0] bw,
                        input logic [63:0] wdata, input int desel, input string tag);
        int eff;
        @(negedge clk);
        if (prev_kind == K_RD) begin
            chk(prev_tag, {63'd0, dq_oe}, 64'd1);
            chk(prev_tag, dq_o, prev_exp);
        end else begin
            chk(prev_tag, {63'd0, dq_oe}, 64'd0);
        end
        dq_i = (prev_kind == K_WR) ? prev_wdata : 64'hDEAD_BEEF_0BAD_F00D;
        if (prev_kind == K_WR) begin
            for (int l = 0; l < 8; l++) begin
                if (!prev_bw[l]) model[prev_adr][l*8 +: 8] = prev_wdata[l*8 +: 8];
            end
        end
        eff = (desel != 0) ? K_NOP : kind;
        adr     = a[9:0];
        rd_wr_n = (kind != K_WR);
        bw_n    = bw;
        sel0_n  = (desel == 1);
        sel1    = (desel != 2);
        sel2_n  = (desel == 3);
        if (kind == K_NOP && desel == 0) sel0_n = 1'b1;
        if (eff == K_RD) prev_exp = model[a];
        prev_kind  = eff;
        prev_adr   = a;
        prev_bw    = bw;
        prev_wdata = wdata;
        prev_tag   = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1;
        dq_i = prev_wdata;
        prev_kind = K_NOP;
        repeat (2) @(negedge clk);
        // R1: outputs cleared while in reset
        chk("R1", {63'd0, dq_oe}, 64'd0);
        chk("R1", dq_o, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_full_rw();
        for (int i = 0; i < 6; i++)
            step(K_WR, 16 + i, 8'h00, {8{8'(i * 37 + 5)}} ^ 64'h0123_4567_89AB_CDEF, 0, "R3");
        step(K_NOP, 0, 8'hFF, '0, 0, "R3");
        for (int i = 0; i < 6; i++) step(K_RD, 16 + i, 8'hFF, '0, 0, "R4");
        step(K_NOP, 0, 8'hFF, '0, 0, "R4");
        step(K_WR, 0, 8'h00, 64'hFFFF_0000_FFFF_0000, 0, "R3");
        step(K_WR, 1023, 8'h00, 64'h5555_AAAA_5555_AAAA, 0, "R3");
        step(K_NOP, 0, 8'hFF, '0, 0, "R3");
        step(K_RD, 1023, 8'hFF, '0, 0, "R4");
        step(K_RD, 0, 8'hFF, '0, 0, "R4");
        step(K_NOP, 0, 8'hFF, '0, 0, "R4");
    endtask

    task automatic t_byte_mask();
        step(K_WR, 100, 8'h00, 64'h1111_2222_3333_4444, 0, "R5");
        step(K_NOP, 0, 8'hFF, '0, 0, "R5");
        step(K_WR, 100, 8'b1010_0101, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R5");
        step(K_NOP, 0, 8'hFF, '0, 0, "R5");
        step(K_WR, 100, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R5");
        step(K_NOP, 0, 8'hFF, '0, 0, "R5");
        step(K_RD, 100, 8'h00, '0, 0, "R5");
        step(K_WR, 100, 8'b0111_1110, 64'h9900_0000_0000_0077, 0, "R5");
        step(K_NOP, 0, 8'hFF, '0, 0, "R5");
        step(K_RD, 100, 8'hFF, '0, 0, "R5");
        step(K_NOP, 0, 8'hFF, '0, 0, "R5");
    endtask

    task automatic t_forward();
        step(K_WR, 200, 8'h00, 64'h0F0F_0F0F_F0F0_F0F0, 0, "R6");
        step(K_RD, 200, 8'hFF, '0, 0, "R6");
        step(K_WR, 200, 8'b1100_0011, 64'h1234_5678_9ABC_DEF0, 0, "R6");
        step(K_RD, 200, 8'hFF, '0, 0, "R6");
        step(K_WR, 201, 8'h00, 64'hCAFE_CAFE_CAFE_CAFE, 0, "R6");
        step(K_RD, 200, 8'hFF, '0, 0, "R6");
        step(K_RD, 201, 8'hFF, '0, 0, "R6");
        step(K_NOP, 0, 8'hFF, '0, 0, "R6");
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 8; i++)
            step(K_WR, 300 + i, 8'h00, {32'(i * 7919), 32'(~i)}, 0, "R7");
        for (int i = 0; i < 8; i++) begin
            step(K_RD, 300 + i, 8'hFF, '0, 0, "R7");
            step(K_WR, 300 + ((i + 3) % 8), 8'(8'h0F << (i % 5)), {2{32'(i * 131 + 9)}}, 0, "R7");
        end
        for (int i = 0; i < 8; i++) step(K_RD, 300 + i, 8'hFF, '0, 0, "R7");
        step(K_NOP, 0, 8'hFF, '0, 0, "R7");
    endtask

    task automatic t_deselect();
        step(K_WR, 400, 8'h00, 64'h7777_6666_5555_4444, 0, "R2");
        for (int d = 1; d <= 3; d++) begin
            step(K_WR, 400, 8'h00, 64'h0, d, "R2");
            step(K_RD, 400, 8'hFF, '0, d, "R2");
        end
        step(K_RD, 400, 8'hFF, '0, 0, "R2");
        step(K_NOP, 0, 8'hFF, '0, 0, "R2");
    endtask

    task automatic t_gwe();
        gwe_n = 1'b0;
        step(K_WR, 500, 8'h00, 64'h8888_9999_AAAA_BBBB, 0, "R8");
        gwe_n = 1'b1;
        step(K_RD, 500, 8'hFF, '0, 0, "R8");
        gwe_n = 1'b0;
        step(K_RD, 500, 8'hFF, '0, 0, "R8");
        step(K_WR, 501, 8'h00, 64'h1, 0, "R8");
        gwe_n = 1'b1;
        step(K_RD, 501, 8'hFF, '0, 0, "R8");
        step(K_NOP, 0, 8'hFF, '0, 0, "R8");
    endtask

    task automatic t_reset_mid();
        step(K_WR, 600, 8'h00, 64'h0000_1111_2222_3333, 0, "R1");
        step(K_NOP, 0, 8'hFF, '0, 0, "R1");
        step(K_WR, 600, 8'h00, 64'hEEEE_EEEE_EEEE_EEEE, 0, "R1");
        do_reset();
        step(K_RD, 600, 8'hFF, '0, 0, "R1");
        step(K_NOP, 0, 8'hFF, '0, 0, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        do_reset();
        t_full_rw();
        t_byte_mask();
        t_forward();
        t_mixed();
        t_deselect();
        t_gwe();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule